// File: doc/BRIEF.md
# Multi-cycle 16-bit load/store core

This block is a small processor core that runs one instruction at a time. Each instruction passes through up to five phases: fetch, decode, execute, memory and write-back. Instructions that need no memory access or register write leave early. Data words and addresses are both 16 bits wide. The core has eight 16-bit general registers and runs seven instructions: word load, word store, register add, register subtract, add-immediate, relative branch, and jump through a register.

The core drives the program counter onto a synchronous instruction-memory read port. The word for that address arrives one clock later. The data-memory port has an address, write data, combinational read data and a write strobe. A debug output shows the current program counter and the phase code. Reset is asynchronous and active low.

Encoding: bits 15:12 hold the major opcode. The first source register field sits in bits 11:9 and the second register field in bits 8:6. Every immediate is sign-extended to 16 bits.

Top module: `mc16_core`

## Requirements
- R1: While `rst_n` is low and on release, `dbg_pc` is 0, `dbg_phase` is 0 (fetch), all eight registers read as 0 and `dmem_we` is 0.
- R2: Phase codes are fetch=0, decode=1, execute=2, memory=3, write-back=4. Fetch is always followed by decode. A load takes 5 cycles, a store or any register write-back instruction takes 4, a jump takes 3, and a branch or no-op takes 2. The PC never changes in the memory or write-back phase.
- R3: In fetch, `imem_addr` equals the PC. At the end of fetch the PC becomes PC+2 (modulo 2^16).
- R4: Load, opcode 0001: the address is reg[11:9] + sext(bits 5:0). The word read there is written to reg[8:6] in write-back.
- R5: Store, opcode 0010: the address is formed as for a load. `dmem_we` is high for exactly the one memory-phase cycle, with `dmem_wdata` = reg[8:6]. No register is written.
- R6: Add-immediate, opcode 0011: reg[11:9] becomes reg[11:9] + sext(bits 8:0).
- R7: Register op, opcode 0110: reg[5:3] becomes reg[11:9] + reg[8:6] when bits 1:0 = 01, or reg[11:9] − reg[8:6] when bits 1:0 = 11. Results wrap modulo 2^16.
- R8: Branch, opcode 0100: the PC becomes (fetch address + 2) + sext(bits 11:0). It finishes after decode.
- R9: Jump, opcode 0101: the PC becomes reg[11:9]. It finishes after execute.
- R10: Any other opcode, and a register op with bits 1:0 = 00 or 10, returns to fetch after decode. It changes no register and writes no memory.
- R11: `dmem_we` is high only in the memory phase of a store. It is never high in the same cycle as a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 16 | Instruction fetch address (the PC) |
| imem_rdata | input | 16 | Instruction word, registered by the memory one cycle after the address |
| dmem_addr | output | 16 | Data-memory byte address |
| dmem_wdata | output | 16 | Store data |
| dmem_rdata | input | 16 | Load data, combinational from `dmem_addr` |
| dmem_we | output | 1 | Store strobe |
| dbg_pc | output | 16 | Current program counter |
| dbg_phase | output | 3 | Current phase code |

## Verification
One program is run and compared on every clock against an instruction-level model of phase, PC and store traffic. The program mixes positive and negative immediates at both ends of the 9-bit range, so sign extension and 16-bit wraparound show up in the stored results. Subtraction is run in both operand orders to separate the order of operands from the sign of the result. A forward branch and a register jump each skip an instruction that would leave a visible mark. An undefined opcode and an undefined register-op function sit in the stream, and later stores show whether either one touched a register. A closing backward branch holds the core in a loop. After that, every register is stored out and compared against values worked out by hand.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
  localparam int WORD_W      = 16;
  localparam int REG_FIELD_W = 3;
  localparam int NUM_REGS    = 1 << REG_FIELD_W;

  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_EXEC   = 3'd2,
    PH_MEM    = 3'd3,
    PH_WB     = 3'd4
  } phase_t;

  typedef enum logic [2:0] {
    K_NOP, K_LOAD, K_STORE, K_ADDI, K_ADD, K_SUB, K_BRANCH, K_JUMP
  } kind_t;

  typedef enum logic [1:0] { ALU_ADD, ALU_SUB, ALU_PASS_A } alu_op_t;

  localparam logic [3:0] OPC_LOAD   = 4'h1;
  localparam logic [3:0] OPC_STORE  = 4'h2;
  localparam logic [3:0] OPC_ADDI   = 4'h3;
  localparam logic [3:0] OPC_BRANCH = 4'h4;
  localparam logic [3:0] OPC_JUMP   = 4'h5;
  localparam logic [3:0] OPC_REGOP  = 4'h6;

  typedef struct packed {
    kind_t                  kind;
    logic [REG_FIELD_W-1:0] src_a;
    logic [REG_FIELD_W-1:0] src_b;
    logic [REG_FIELD_W-1:0] dst;
    logic [WORD_W-1:0]      imm;
  } dec_t;

  // Field split of one instruction word
  function automatic dec_t decode_word(input logic [WORD_W-1:0] w);
    dec_t d;
    d.kind  = K_NOP;
    d.src_a = w[11:9];
    d.src_b = w[8:6];
    d.dst   = w[8:6];
    d.imm   = WORD_W'($signed(w[5:0]));
    case (w[15:12])
      OPC_LOAD:   d.kind = K_LOAD;
      OPC_STORE:  d.kind = K_STORE;
      OPC_ADDI: begin
        d.kind = K_ADDI;
        d.dst  = w[11:9];
        d.imm  = WORD_W'($signed(w[8:0]));
      end
      OPC_BRANCH: begin
        d.kind = K_BRANCH;
        d.imm  = WORD_W'($signed(w[11:0]));
      end
      OPC_JUMP:   d.kind = K_JUMP;
      OPC_REGOP: begin
        d.dst = w[5:3];
        case (w[1:0])
          2'b01:   d.kind = K_ADD;
          2'b11:   d.kind = K_SUB;
          default: d.kind = K_NOP;
        endcase
      end
      default: d.kind = K_NOP;
    endcase
    return d;
  endfunction

  function automatic logic [WORD_W-1:0] alu_eval(input alu_op_t op,
                                                 input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
    case (op)
      ALU_ADD: return a + b;
      ALU_SUB: return a - b;
      default: return a;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] pc_step(input logic [WORD_W-1:0] pc);
    return pc + WORD_W'(2);
  endfunction

  function automatic logic [WORD_W-1:0] pc_rel(input logic [WORD_W-1:0] pc,
                                               input logic [WORD_W-1:0] off);
    return pc + off;
  endfunction
endpackage

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
  parameter int NREG  = 8,
  parameter int WIDTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NREG)-1:0]  rd_idx_a,
  input  logic [$clog2(NREG)-1:0]  rd_idx_b,
  output logic [WIDTH-1:0]         rd_val_a,
  output logic [WIDTH-1:0]         rd_val_b,
  input  logic                     wr_en,
  input  logic [$clog2(NREG)-1:0]  wr_idx,
  input  logic [WIDTH-1:0]         wr_val
);
  logic [WIDTH-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_en && wr_idx == g)
        regs[g] <= wr_val;
    end
  end

  assign rd_val_a = regs[rd_idx_a];
  assign rd_val_b = regs[rd_idx_b];
endmodule

// File: rtl/mc16_alu.sv
module mc16_alu
  import mc16_pkg::*;
#(
  parameter int WIDTH = WORD_W
) (
  input  alu_op_t          op,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] result
);
  assign result = alu_eval(op, opnd_a, opnd_b);
endmodule

// File: rtl/mc16_phase_seq.sv
module mc16_phase_seq
  import mc16_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  kind_t  kind,
  output phase_t phase
);
  phase_t phase_nxt;

  always_comb begin
    phase_nxt = PH_FETCH;
    case (phase)
      PH_FETCH:  phase_nxt = PH_DECODE;
      PH_DECODE: phase_nxt = (kind == K_BRANCH || kind == K_NOP) ? PH_FETCH : PH_EXEC;
      PH_EXEC: begin
        if (kind == K_JUMP)
          phase_nxt = PH_FETCH;
        else if (kind == K_LOAD || kind == K_STORE)
          phase_nxt = PH_MEM;
        else
          phase_nxt = PH_WB;
      end
      PH_MEM:    phase_nxt = (kind == K_LOAD) ? PH_WB : PH_FETCH;
      default:   phase_nxt = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_FETCH;
    else        phase <= phase_nxt;
  end
endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] imem_addr,
  input  logic [W-1:0] imem_rdata,
  output logic [W-1:0] dmem_addr,
  output logic [W-1:0] dmem_wdata,
  input  logic [W-1:0] dmem_rdata,
  output logic         dmem_we,
  output logic [W-1:0] dbg_pc,
  output logic [2:0]   dbg_phase
);
  localparam int NREG = NUM_REGS;

  phase_t      phase;
  logic [W-1:0] pc, ir, opnd_a_q, opnd_b_q, alu_q, mdr;
  logic [W-1:0] cur_word, alu_b, alu_y, rf_rd_a, rf_rd_b, rf_wd;
  dec_t        dec;
  alu_op_t     alu_op;

  // Named internal events, used by the checker
  logic rf_we, pc_from_branch, pc_from_jump, fetch_done;

  // The fetched word is on imem_rdata only during decode; later phases use ir
  assign cur_word = (phase == PH_DECODE) ? imem_rdata : ir;
  assign dec      = decode_word(cur_word);

  assign fetch_done     = (phase == PH_FETCH);
  assign pc_from_branch = (phase == PH_DECODE) && (dec.kind == K_BRANCH);
  assign pc_from_jump   = (phase == PH_EXEC) && (dec.kind == K_JUMP);
  assign rf_we          = (phase == PH_WB);
  assign rf_wd          = (dec.kind == K_LOAD) ? mdr : alu_q;

  always_comb begin
    case (dec.kind)
      K_SUB:   alu_op = ALU_SUB;
      K_JUMP:  alu_op = ALU_PASS_A;
      default: alu_op = ALU_ADD;
    endcase
  end
  assign alu_b = (dec.kind == K_ADD || dec.kind == K_SUB) ? opnd_b_q : dec.imm;

  mc16_phase_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .kind  (dec.kind),
    .phase (phase)
  );

  mc16_regfile #(.NREG(NREG), .WIDTH(W)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx_a (dec.src_a),
    .rd_idx_b (dec.src_b),
    .rd_val_a (rf_rd_a),
    .rd_val_b (rf_rd_b),
    .wr_en    (rf_we),
    .wr_idx   (dec.dst),
    .wr_val   (rf_wd)
  );

  mc16_alu #(.WIDTH(W)) u_alu (
    .op     (alu_op),
    .opnd_a (opnd_a_q),
    .opnd_b (alu_b),
    .result (alu_y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc       <= '0;
      ir       <= '0;
      opnd_a_q <= '0;
      opnd_b_q <= '0;
      alu_q    <= '0;
      mdr      <= '0;
    end else begin
      case (phase)
        PH_FETCH: pc <= pc_step(pc);
        PH_DECODE: begin
          ir       <= imem_rdata;
          opnd_a_q <= rf_rd_a;
          opnd_b_q <= rf_rd_b;
          if (pc_from_branch) pc <= pc_rel(pc, dec.imm);
        end
        PH_EXEC: begin
          alu_q <= alu_y;
          if (pc_from_jump) pc <= alu_y;
        end
        PH_MEM:  mdr <= dmem_rdata;
        default: ;
      endcase
    end
  end

  assign imem_addr  = pc;
  assign dmem_addr  = alu_q;
  assign dmem_wdata = opnd_b_q;
  assign dmem_we    = (phase == PH_MEM) && (dec.kind == K_STORE);
  assign dbg_pc     = pc;
  assign dbg_phase  = phase;
endmodule

// File: rtl/mc16_core_chk.sv
module mc16_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  phase,
  input logic [15:0] pc,
  input logic        rf_we,
  input logic        dmem_we,
  input logic        fetch_done,
  input logic        pc_from_branch,
  input logic        pc_from_jump
);
  assert_phase_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= 3'd4);

  assert_decode_after_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> phase == 3'd1);

  assert_pc_quiet_late_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3 || phase == 3'd4) |=> $stable(pc));

  assert_pc_plus_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> pc == $past(pc) + 16'd2);

  assert_store_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |=> phase == 3'd0);

  assert_branch_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_from_branch |=> phase == 3'd0);

  assert_jump_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_from_jump |=> phase == 3'd0);

  assert_we_only_mem_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (phase == 3'd3 && !rf_we));
endmodule

bind mc16_core mc16_core_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .phase          (dbg_phase),
  .pc             (dbg_pc),
  .rf_we          (rf_we),
  .dmem_we        (dmem_we),
  .fetch_done     (fetch_done),
  .pc_from_branch (pc_from_branch),
  .pc_from_jump   (pc_from_jump)
);

// File: tb/mc16_core_bench.sv
`timescale 1ns/1ps
module mc16_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata, dbg_pc;
  logic        dmem_we;
  logic [2:0]  dbg_phase;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  logic [15:0] imem [64];
  logic [15:0] dmem [64];

  always #5 clk = ~clk;

  mc16_core u_mc16_core (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .dmem_we(dmem_we), .dbg_pc(dbg_pc), .dbg_phase(dbg_phase)
  );

  always @(posedge clk) imem_rdata <= imem[imem_addr[6:1]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[6:1]] <= dmem_wdata;
  assign dmem_rdata = dmem[dmem_addr[6:1]];

  // ---- encoders ----
  function automatic logic [15:0] e_mem(int opc, int base, int r, int off);
    return 16'((opc << 12) | (base << 9) | (r << 6) | (off & 63));
  endfunction
  function automatic logic [15:0] e_addi(int r, int v);
    return 16'((3 << 12) | (r << 9) | (v & 511));
  endfunction
  function automatic logic [15:0] e_rr(int s, int t, int d, int fn);
    return 16'((6 << 12) | (s << 9) | (t << 6) | (d << 3) | fn);
  endfunction
  function automatic logic [15:0] e_br(int off);
    return 16'((4 << 12) | (off & 4095));
  endfunction
  function automatic logic [15:0] e_jr(int r);
    return 16'((5 << 12) | (r << 9));
  endfunction
  function automatic int sx(int v, int bits);
    return (v ^ (1 << (bits - 1))) - (1 << (bits - 1));
  endfunction

  task automatic check(bit ok, string req, string what, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // ---- reference model, instruction level ----
  logic [15:0] m_pc, m_ir, m_a, m_b, m_res, m_addr;
  logic [15:0] m_regs [8];
  logic [15:0] m_mem  [64];
  int m_phase, m_opc, m_fn;
  string m_pc_tag, m_tag;

  task automatic model_step();
    int opc, fn, rs, rt, rd;
    opc = int'(m_ir[15:12]); fn = int'(m_ir[1:0]);
    rs = int'(m_ir[11:9]); rt = int'(m_ir[8:6]); rd = int'(m_ir[5:3]);
    case (m_phase)
      0: begin m_ir = imem[m_pc[6:1]]; m_pc = m_pc + 16'd2; m_pc_tag = "R3"; m_phase = 1; end
      1: begin
        m_a = m_regs[rs]; m_b = m_regs[rt];
        if (opc == 4) begin
          m_pc = 16'(int'(m_pc) + sx(int'(m_ir[11:0]), 12)); m_pc_tag = "R8"; m_phase = 0;
        end else if (opc >= 1 && opc <= 5) m_phase = 2;
        else if (opc == 6 && (fn == 1 || fn == 3)) m_phase = 2;
        else m_phase = 0;
      end
      2: begin
        if (opc == 5) begin m_pc = m_a; m_pc_tag = "R9"; m_phase = 0; end
        else if (opc == 1 || opc == 2) begin
          m_addr = 16'(int'(m_a) + sx(int'(m_ir[5:0]), 6)); m_phase = 3;
        end else begin
          if (opc == 3) m_res = 16'(int'(m_a) + sx(int'(m_ir[8:0]), 9));
          else if (fn == 1) m_res = m_a + m_b;
          else m_res = m_a - m_b;
          m_phase = 4;
        end
      end
      3: begin
        if (opc == 2) begin m_mem[m_addr[6:1]] = m_b; m_phase = 0; end
        else begin m_res = m_mem[m_addr[6:1]]; m_phase = 4; end
      end
      default: begin
        if (opc == 1) m_regs[rt] = m_res;
        else if (opc == 3) m_regs[rs] = m_res;
        else m_regs[rd] = m_res;
        m_phase = 0;
      end
    endcase
  endtask

  task automatic compare_cycle();
    bit exp_we;
    int opc, fn;
    opc = int'(m_ir[15:12]); fn = int'(m_ir[1:0]);
    m_tag = "R2";
    if (m_phase != 0 && !(opc >= 1 && opc <= 5) && !(opc == 6 && (fn == 1 || fn == 3)))
      m_tag = "R10";
    exp_we = (m_phase == 3 && opc == 2);
    check(dbg_phase == 3'(m_phase), m_tag, "phase", 16'(dbg_phase), 16'(m_phase));
    check(dbg_pc == m_pc, m_pc_tag, "pc", dbg_pc, m_pc);
    check(dmem_we == exp_we, "R11", "dmem_we", 16'(dmem_we), 16'(exp_we));
    if (m_phase == 0)
      check(imem_addr == m_pc, "R3", "imem_addr", imem_addr, m_pc);
    if (exp_we) begin
      check(dmem_addr == m_addr, "R5", "store address", dmem_addr, m_addr);
      check(dmem_wdata == m_b, "R5", "store data", dmem_wdata, m_b);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin imem[i] = 16'hF000; dmem[i] = 16'h0000; m_mem[i] = 16'h0000; end
    for (int i = 0; i < 8; i++) m_regs[i] = 16'h0;
    imem[0]  = e_addi(1, 5);
    imem[1]  = e_addi(2, -3);
    imem[2]  = e_rr(1, 2, 3, 1);      // r3 = r1 + r2
    imem[3]  = e_rr(1, 2, 4, 3);      // r4 = r1 - r2
    imem[4]  = e_rr(2, 1, 5, 3);      // r5 = r2 - r1
    imem[5]  = e_addi(6, 255);
    imem[6]  = e_addi(6, -256);
    imem[7]  = e_rr(6, 1, 7, 1);      // wraps
    imem[8]  = e_mem(2, 0, 3, 10);    // store r3 at 10
    imem[9]  = e_mem(2, 1, 5, -1);    // store r5 at 4
    imem[10] = e_mem(1, 0, 1, 10);    // load r1 from 10
    imem[11] = 16'hF123;              // undefined opcode
    imem[12] = e_rr(1, 1, 1, 0);      // undefined function
    imem[13] = e_br(2);               // skip next
    imem[14] = e_addi(1, 100);
    imem[15] = e_addi(2, 40);
    imem[16] = e_addi(4, 30);         // r4 = 38
    imem[17] = e_jr(4);
    imem[18] = e_addi(7, 1);
    for (int k = 0; k < 8; k++) imem[19 + k] = e_mem(2, 0, k, 12 + 2 * k);
    imem[27] = e_br(-2);              // hold loop

    m_pc = 0; m_ir = 0; m_phase = 0; m_a = 0; m_b = 0; m_res = 0; m_addr = 0;
    m_pc_tag = "R3";

    repeat (3) @(negedge clk);
    check(dbg_pc == 16'h0, "R1", "pc in reset", dbg_pc, 16'h0);
    check(dbg_phase == 3'd0, "R1", "phase in reset", 16'(dbg_phase), 16'h0);
    check(dmem_we == 1'b0, "R1", "we in reset", 16'(dmem_we), 16'h0);
    rst_n = 1'b1;

    for (int cyc = 0; cyc < 260; cyc++) begin
      compare_cycle();
      model_step();
      @(negedge clk);
    end

    // Hand-worked register images stored at 12 + 2k
    check(dmem[6]  == 16'h0000, "R1",  "r0 never written", dmem[6],  16'h0000);
    check(dmem[7]  == 16'h0002, "R4",  "r1 loaded",        dmem[7],  16'h0002);
    check(dmem[8]  == 16'h0025, "R6",  "r2 addi neg+pos",  dmem[8],  16'h0025);
    check(dmem[9]  == 16'h0002, "R7",  "r3 add",           dmem[9],  16'h0002);
    check(dmem[10] == 16'h0026, "R9",  "r4 jump target",   dmem[10], 16'h0026);
    check(dmem[11] == 16'hFFF8, "R7",  "r5 sub negative",  dmem[11], 16'hFFF8);
    check(dmem[12] == 16'hFFFF, "R6",  "r6 addi extremes", dmem[12], 16'hFFFF);
    check(dmem[13] == 16'h0004, "R7",  "r7 wrap, skipped", dmem[13], 16'h0004);
    check(dmem[5]  == 16'h0002, "R5",  "store at 10",      dmem[5],  16'h0002);
    check(dmem[2]  == 16'hFFF8, "R4",  "neg offset addr",  dmem[2],  16'hFFF8);
    check(dbg_pc == 16'd54 || dbg_pc == 16'd56, "R8", "hold loop pc", dbg_pc, 16'd54);
    for (int i = 0; i < 64; i++)
      check(dmem[i] == m_mem[i], "R5", "memory image", dmem[i], m_mem[i]);
    finish_run();
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule